// File: doc/BRIEF.md
# BCD Real-Time Calendar

This block keeps wall-clock time and calendar date in packed BCD. A two-stage divider turns the calendar clock input into a one-per-second tick. Each tick advances seconds, minutes and hours in 24-hour form, then the day of the month, the weekday, the month and a two-digit year. Month lengths and leap years are followed for the years 2000 to 2099.

Software changes the calendar through a small write port. To load a new time, date or divider setting it first requests an initialization mode and waits for an acknowledge flag. While that flag is high the counters and the divider stand still, and only then are the time, date and divider words accepted. Clearing the request lets counting resume. A resync flag tells software that the readable calendar words are fresh. Software clears it, and hardware sets it again two edges after the counters change or after the init mode ends.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: After reset the time word is 00:00:00, the date word reads day 01, month 01, weekday 6 and year 00 (0x0000C101), the divider word reads 0x007F00FF (A=127, S=255), and init_active, sync_ok and cal_valid are 0.
- R2: Writes with wr_sel 0 (time: seconds [6:0], minutes [14:8], hours [21:16]), 1 (date: day [5:0], month [12:8], weekday [15:13], year [23:16]) or 2 (divider: A in [22:16], S in [14:0]) take effect only while init_active is 1 and are otherwise ignored.
- R3: A write with wr_sel 3 sets the init request from wr_data[0]. init_active rises on the second clock edge after a write that sets the request and falls on the second edge after a write that clears it.
- R4: While init_active is 1 the calendar counters hold their value and sec_tick stays 0.
- R5: sec_tick pulses once every (A+1)*(S+1) clock cycles while counting.
- R6: Seconds and minutes count in BCD from 00 to 59 and hours from 00 to 23. 23:59:59 wraps to 00:00:00 and carries into the date. The weekday advances with each day and wraps from 7 to 1.
- R7: The day of the month rolls back to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and in month 02 after day 29 when the year value is divisible by 4 and after day 28 otherwise.
- R8: Month 12 wraps to month 01 and increments the year. Year 99 wraps to 00.
- R9: cal_valid is 1 exactly when the year field is non-zero.
- R10: A write with wr_sel 3 and wr_data[2]=1 clears sync_ok. sync_ok is set again on the second edge after a calendar advance, and on the second edge after init_active falls.
- R11: When a clear of sync_ok and a hardware set of sync_ok fall on the same edge, the set wins.
- R12: The hour-format control wr_data[1] of a wr_sel 3 write is ignored, and hours always count in 24-hour form (12:59:59 goes to 13:00:00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calendar clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 time, 1 date, 2 divider, 3 control |
| wr_data | input | 32 | Write data |
| time_word | output | 32 | Current time, packed BCD |
| date_word | output | 32 | Current date, packed BCD |
| div_word | output | 32 | Divider setting |
| init_active | output | 1 | Init mode acknowledged, counters frozen |
| sync_ok | output | 1 | Calendar words resynchronized |
| cal_valid | output | 1 | Year field non-zero |
| sec_tick | output | 1 | One-cycle pulse at each calendar advance |

## Verification
The resync flag has two writers that can hit it on the same edge: a software clear and the hardware set that follows a calendar advance. With the divider at its fastest setting the calendar advances on every edge, so a set is always pending. A clear written then must leave sync_ok at 1 when it is sampled right after that edge. In a quiet window inside init mode, with no set pending, the same clear must drop the flag to 0.

// File: rtl/bcd_rtc_pkg.sv
`timescale 1ns/1ps
package bcd_rtc_pkg;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } hms_t;

  typedef struct packed {
    logic [7:0] year;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [5:0] day;
  } ymd_t;

  localparam logic [2:0] RST_WDAY = 3'd6;

  // Add one to a two-digit BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a month (BCD), leap rule on the two-digit year.
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [7:0] bin;
    bin = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      5'h02:                      return (bin[1:0] == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_rtc_divider.sv
`timescale 1ns/1ps
module bcd_rtc_divider #(
  parameter int ADIV_W   = 7,
  parameter int SDIV_W   = 15,
  parameter int ADIV_RST = 127,
  parameter int SDIV_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              ld,
  input  logic [ADIV_W-1:0] ld_a,
  input  logic [SDIV_W-1:0] ld_s,
  output logic [ADIV_W-1:0] a_div,
  output logic [SDIV_W-1:0] s_div,
  output logic              tick
);

  logic [ADIV_W-1:0] a_div_q, a_div_n, a_cnt_q, a_cnt_n;
  logic [SDIV_W-1:0] s_div_q, s_div_n, s_cnt_q, s_cnt_n;
  logic a_wrap, s_wrap;

  assign a_wrap = (a_cnt_q == a_div_q);
  assign s_wrap = (s_cnt_q == s_div_q);
  assign tick   = !hold && a_wrap && s_wrap;

  always_comb begin
    a_div_n = a_div_q;
    s_div_n = s_div_q;
    a_cnt_n = a_cnt_q;
    s_cnt_n = s_cnt_q;
    if (ld) begin
      a_div_n = ld_a;
      s_div_n = ld_s;
    end
    if (hold) begin
      a_cnt_n = '0;
      s_cnt_n = '0;
    end else if (a_wrap) begin
      a_cnt_n = '0;
      s_cnt_n = s_wrap ? '0 : s_cnt_q + 1'b1;
    end else begin
      a_cnt_n = a_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_div_q <= ADIV_W'(ADIV_RST);
      s_div_q <= SDIV_W'(SDIV_RST);
      a_cnt_q <= '0;
      s_cnt_q <= '0;
    end else begin
      a_div_q <= a_div_n;
      s_div_q <= s_div_n;
      a_cnt_q <= a_cnt_n;
      s_cnt_q <= s_cnt_n;
    end
  end

  assign a_div = a_div_q;
  assign s_div = s_div_q;

  // R4
  held_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (a_cnt_q == '0 && s_cnt_q == '0));

endmodule

// File: rtl/bcd_rtc_counter.sv
`timescale 1ns/1ps
module bcd_rtc_counter
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              tick,
  input  logic              ld_time,
  input  logic              ld_date,
  input  logic [WORD_W-1:0] wdata,
  output hms_t              hms,
  output ymd_t              ymd
);

  hms_t t_q, t_n;
  ymd_t d_q, d_n;
  logic adv, s_top, m_top, h_top, d_top, mo_top;

  assign adv    = tick && !hold;
  assign s_top  = (t_q.sec  == 7'h59);
  assign m_top  = (t_q.min  == 7'h59);
  assign h_top  = (t_q.hour == 6'h23);
  assign d_top  = (d_q.day  == last_day(d_q.mon, d_q.year));
  assign mo_top = (d_q.mon  == 5'h12);

  always_comb begin
    t_n = t_q;
    d_n = d_q;
    if (ld_time) begin
      t_n.sec  = wdata[6:0];
      t_n.min  = wdata[14:8];
      t_n.hour = wdata[21:16];
    end
    if (ld_date) begin
      d_n.day  = wdata[5:0];
      d_n.mon  = wdata[12:8];
      d_n.wday = wdata[15:13];
      d_n.year = wdata[23:16];
    end
    if (adv) begin
      t_n.sec = s_top ? 7'h00 : 7'(bcd_inc({1'b0, t_q.sec}));
      if (s_top) begin
        t_n.min = m_top ? 7'h00 : 7'(bcd_inc({1'b0, t_q.min}));
        if (m_top) begin
          t_n.hour = h_top ? 6'h00 : 6'(bcd_inc({2'b0, t_q.hour}));
          if (h_top) begin
            d_n.wday = (d_q.wday == 3'd7) ? 3'd1 : d_q.wday + 3'd1;
            d_n.day  = d_top ? 6'h01 : 6'(bcd_inc({2'b0, d_q.day}));
            if (d_top) begin
              d_n.mon = mo_top ? 5'h01 : 5'(bcd_inc({3'b0, d_q.mon}));
              if (mo_top) d_n.year = (d_q.year == 8'h99) ? 8'h00 : bcd_inc(d_q.year);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      d_q <= '{year: 8'h00, wday: RST_WDAY, mon: 5'h01, day: 6'h01};
    end else begin
      t_q <= t_n;
      d_q <= d_n;
    end
  end

  assign hms = t_q;
  assign ymd = d_q;

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ld_time && !ld_date) |=> ($stable(t_q) && $stable(d_q)));
  // R6
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && t_q.sec == 7'h59) |=> (t_q.sec == 7'h00));
  // R7
  feb_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && t_q == '{hour: 6'h23, min: 7'h59, sec: 7'h59} && d_q.mon == 5'h02 && d_q.day == 6'h29)
      |=> (d_q.day == 6'h01 && d_q.mon == 5'h03));

endmodule

// File: rtl/bcd_rtc_ctrl.sv
`timescale 1ns/1ps
module bcd_rtc_ctrl #(
  parameter int HS_STAGES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic req_bit,
  input  logic clr_bit,
  input  logic upd,
  output logic init_active,
  output logic sync_ok
);

  logic                   req_q, req_n;
  logic [HS_STAGES-1:0]   hs_q, hs_n;
  logic [SYNC_STAGES-1:0] sp_q, sp_n;
  logic                   sync_q, sync_n;
  logic                   exit_evt, set_now, clr_now;

  assign init_active = hs_q[HS_STAGES-1];
  assign exit_evt    = init_active && !hs_q[HS_STAGES-2];
  assign set_now     = sp_q[SYNC_STAGES-1];
  assign clr_now     = ctl_wr && clr_bit;

  always_comb begin
    req_n  = ctl_wr ? req_bit : req_q;
    hs_n   = {hs_q[HS_STAGES-2:0], req_q};
    sp_n   = {sp_q[SYNC_STAGES-2:0], upd || exit_evt};
    sync_n = set_now ? 1'b1 : (clr_now ? 1'b0 : sync_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      hs_q   <= '0;
      sp_q   <= '0;
      sync_q <= 1'b0;
    end else begin
      req_q  <= req_n;
      hs_q   <= hs_n;
      sp_q   <= sp_n;
      sync_q <= sync_n;
    end
  end

  assign sync_ok = sync_q;

  // R10
  sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !set_now) |=> !sync_ok);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> sync_ok);

endmodule

// File: rtl/bcd_rtc_calendar.sv
`timescale 1ns/1ps
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
#(
  parameter int ADIV_W   = 7,
  parameter int SDIV_W   = 15,
  parameter int ADIV_RST = 127,
  parameter int SDIV_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] time_word,
  output logic [WORD_W-1:0] date_word,
  output logic [WORD_W-1:0] div_word,
  output logic              init_active,
  output logic              sync_ok,
  output logic              cal_valid,
  output logic              sec_tick
);

  localparam int A_POS = 16;

  logic [1:0]        rs_q;
  logic              rst_s;
  logic              ld_time, ld_date, ld_div, ctl_wr;
  logic [ADIV_W-1:0] a_div;
  logic [SDIV_W-1:0] s_div;
  hms_t              hms;
  ymd_t              ymd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign ld_time = wr_en && init_active && (wr_sel == 2'd0);
  assign ld_date = wr_en && init_active && (wr_sel == 2'd1);
  assign ld_div  = wr_en && init_active && (wr_sel == 2'd2);
  assign ctl_wr  = wr_en && (wr_sel == 2'd3);

  bcd_rtc_divider #(
    .ADIV_W(ADIV_W), .SDIV_W(SDIV_W), .ADIV_RST(ADIV_RST), .SDIV_RST(SDIV_RST)
  ) u_div (
    .clk(clk), .rst_n(rst_s), .hold(init_active), .ld(ld_div),
    .ld_a(wr_data[A_POS +: ADIV_W]), .ld_s(wr_data[SDIV_W-1:0]),
    .a_div(a_div), .s_div(s_div), .tick(sec_tick)
  );

  bcd_rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_s), .hold(init_active), .tick(sec_tick),
    .ld_time(ld_time), .ld_date(ld_date), .wdata(wr_data),
    .hms(hms), .ymd(ymd)
  );

  bcd_rtc_ctrl u_ctl (
    .clk(clk), .rst_n(rst_s), .ctl_wr(ctl_wr), .req_bit(wr_data[0]),
    .clr_bit(wr_data[2]), .upd(sec_tick),
    .init_active(init_active), .sync_ok(sync_ok)
  );

  assign time_word = {10'd0, hms.hour, 1'b0, hms.min, 1'b0, hms.sec};
  assign date_word = {8'd0, ymd.year, ymd.wday, ymd.mon, 2'b00, ymd.day};
  assign div_word  = (WORD_W'(a_div) << A_POS) | WORD_W'(s_div);
  assign cal_valid = (ymd.year != 8'h00);

endmodule

// File: tb/bcd_rtc_calendar_bench.sv
`timescale 1ns/1ps
module bcd_rtc_calendar_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] time_word, date_word, div_word;
  logic        init_active, sync_ok, cal_valid, sec_tick;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bcd_rtc_calendar u_bcd_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .time_word(time_word), .date_word(date_word), .div_word(div_word),
    .init_active(init_active), .sync_ok(sync_ok), .cal_valid(cal_valid),
    .sec_tick(sec_tick)
  );

  function automatic logic [31:0] tw(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    return {8'd0, h, m, s};
  endfunction

  function automatic logic [31:0] dw(input logic [7:0] y, input logic [7:0] mo,
                                     input logic [7:0] d, input logic [2:0] w);
    return {8'd0, y, w, mo[4:0], d};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter_init(input logic [31:0] ctl);
    wr(2'd3, ctl);
    repeat (2) @(negedge clk);
  endtask

  task automatic exit_init();
    wr(2'd3, 32'h0);
    @(negedge clk);
  endtask

  task automatic adv(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (sec_tick) k++;
    end
    @(negedge clk);
  endtask

  task automatic roll(input string tag, input logic [31:0] ctl,
                      input logic [31:0] t0, input logic [31:0] d0,
                      input logic [31:0] t1, input logic [31:0] d1);
    enter_init(ctl);
    wr(2'd2, 32'h0);
    wr(2'd0, t0);
    wr(2'd1, d0);
    exit_init();
    adv(1);
    chk({tag, " time"}, time_word, t1);
    chk({tag, " date"}, date_word, d1);
  endtask

  task automatic t_reset();
    chk("R1 time", time_word, 32'h0);
    chk("R1 date", date_word, 32'h0000C101);
    chk("R1 div", div_word, 32'h007F00FF);
    chk("R1 flags", {29'd0, init_active, sync_ok, cal_valid}, 32'h0);
  endtask

  task automatic t_ignore();
    wr(2'd0, tw(8'h12, 8'h34, 8'h56));
    wr(2'd1, dw(8'h23, 8'h05, 8'h06, 3'd2));
    wr(2'd2, 32'h0);
    chk("R2 time ignored", time_word, 32'h0);
    chk("R2 date ignored", date_word, 32'h0000C101);
    chk("R2 div ignored", div_word, 32'h007F00FF);
  endtask

  task automatic t_handshake();
    wr(2'd3, 32'h1);
    @(negedge clk); chk("R3 init after 1 edge", {31'd0, init_active}, 32'd0);
    @(negedge clk); chk("R3 init after 2 edges", {31'd0, init_active}, 32'd1);
    wr(2'd0, tw(8'h12, 8'h34, 8'h56));
    chk("R2 time loaded", time_word, 32'h00123456);
    wr(2'd3, 32'h0);
    @(negedge clk); chk("R3 still init 1 edge", {31'd0, init_active}, 32'd1);
    @(negedge clk); chk("R3 init dropped", {31'd0, init_active}, 32'd0);
    @(negedge clk); chk("R10 sync not yet", {31'd0, sync_ok}, 32'd0);
    @(negedge clk); chk("R10 sync after exit", {31'd0, sync_ok}, 32'd1);
    wr(2'd3, 32'h4);
    chk("R10 sync cleared", {31'd0, sync_ok}, 32'd0);
  endtask

  task automatic t_period();
    int n = 0;
    enter_init(32'h1);
    wr(2'd2, (32'd3 << 16) | 32'd4);
    chk("R2 div loaded", div_word, 32'h00030004);
    exit_init();
    while (!sec_tick) @(negedge clk);
    do begin
      @(negedge clk);
      n++;
    end while (!sec_tick);
    chk("R5 tick period", n, 32'd20);
  endtask

  task automatic t_freeze();
    logic [31:0] t0;
    logic        seen = 1'b0;
    roll("R6 sec digit", 32'h1, tw(8'h00, 8'h00, 8'h09), dw(8'h23, 8'h01, 8'h10, 3'd2),
         tw(8'h00, 8'h00, 8'h10), dw(8'h23, 8'h01, 8'h10, 3'd2));
    enter_init(32'h1);
    t0 = time_word;
    repeat (10) begin
      @(negedge clk);
      if (sec_tick) seen = 1'b1;
    end
    chk("R4 time frozen", time_word, t0);
    chk("R4 no tick in init", {31'd0, seen}, 32'd0);
    exit_init();
  endtask

  task automatic t_collision();
    adv(4);
    chk("R11 sync set before clear", {31'd0, sync_ok}, 32'd1);
    wr(2'd3, 32'h4);
    chk("R11 set wins over clear", {31'd0, sync_ok}, 32'd1);
  endtask

  task automatic t_rollover();
    roll("R6 minute carry", 32'h1, tw(8'h00, 8'h59, 8'h59), dw(8'h23, 8'h01, 8'h15, 3'd7),
         tw(8'h01, 8'h00, 8'h00), dw(8'h23, 8'h01, 8'h15, 3'd7));
    chk("R9 valid year 23", {31'd0, cal_valid}, 32'd1);
    roll("R6 day wday wrap", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h23, 8'h01, 8'h15, 3'd7),
         tw(8'h00, 8'h00, 8'h00), dw(8'h23, 8'h01, 8'h16, 3'd1));
    roll("R8 new year", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h23, 8'h12, 8'h31, 3'd7),
         tw(8'h00, 8'h00, 8'h00), dw(8'h24, 8'h01, 8'h01, 3'd1));
    roll("R7 jan end", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h23, 8'h01, 8'h31, 3'd2),
         tw(8'h00, 8'h00, 8'h00), dw(8'h23, 8'h02, 8'h01, 3'd3));
    roll("R7 apr end", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h23, 8'h04, 8'h30, 3'd7),
         tw(8'h00, 8'h00, 8'h00), dw(8'h23, 8'h05, 8'h01, 3'd1));
    roll("R7 feb28 common", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h23, 8'h02, 8'h28, 3'd2),
         tw(8'h00, 8'h00, 8'h00), dw(8'h23, 8'h03, 8'h01, 3'd3));
    roll("R7 feb28 leap", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h24, 8'h02, 8'h28, 3'd3),
         tw(8'h00, 8'h00, 8'h00), dw(8'h24, 8'h02, 8'h29, 3'd4));
    roll("R7 feb29 leap", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h24, 8'h02, 8'h29, 3'd4),
         tw(8'h00, 8'h00, 8'h00), dw(8'h24, 8'h03, 8'h01, 3'd5));
    roll("R8 century wrap", 32'h1, tw(8'h23, 8'h59, 8'h59), dw(8'h99, 8'h12, 8'h31, 3'd4),
         tw(8'h00, 8'h00, 8'h00), dw(8'h00, 8'h01, 8'h01, 3'd5));
    chk("R9 valid year 00", {31'd0, cal_valid}, 32'd0);
    roll("R12 24h format", 32'h3, tw(8'h12, 8'h59, 8'h59), dw(8'h23, 8'h06, 8'h10, 3'd6),
         tw(8'h13, 8'h00, 8'h00), dw(8'h23, 8'h06, 8'h10, 3'd6));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ignore();
    t_handshake();
    t_period();
    t_freeze();
    t_collision();
    t_rollover();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule